// File: doc/BRIEF.md
# External-Memory Ring FIFO Controller

This block turns a region of external memory into one deep first-in first-out queue for a continuous byte stream. Bytes arrive on a valid/ready sink and collect in a small on-chip staging FIFO. A write engine moves them, one word per transfer, into a circular region of external memory. A read engine fetches words back in the same order into a second on-chip staging FIFO, which drives a valid/ready byte source. Both engines share one memory-mapped port that has a wait-request and a read-data-valid signal.

The controller keeps a write position and a read position as two separate counters. Each counts modulo the ring size and is offset by a fixed base address. An occupancy count stops the write position from lapping the read position and stops the read position from passing the write position. When both engines have work, a round-robin arbiter shares the port between them. Transfers are single words with no bursts, and at most one read is outstanding.

Top module: `ext_fifo_ctrl`

## Requirements
- R1: `in_ready` is high exactly when the input staging FIFO has room. With `out_ready` held low from reset, the block accepts exactly RING_WORDS + 2*STAGE_DEPTH bytes and then holds `in_ready` low.
- R2: `out_valid` is high exactly when the output staging FIFO holds data. Bytes leave in the order they were accepted, with none lost and none duplicated. While `out_valid` is high and `out_ready` is low, `out_data` does not change.
- R3: The count of words held in memory never exceeds RING_WORDS, and no write is issued while memory holds RING_WORDS words.
- R4: No read is issued while memory holds zero words.
- R5: Counting accepted transfers from zero after reset, the n-th write goes to address RING_BASE + (n mod RING_WORDS), and the n-th read goes to RING_BASE + (n mod RING_WORDS).
- R6: While `mem_waitrequest` is high, an issued command keeps its command line, its address and its write data unchanged.
- R7: `mem_write` and `mem_read` are never high together. Once a read has been accepted, no new command is issued until `mem_readdatavalid` delivers its word, and only that cycle's `mem_readdata` is stored.
- R8: When both engines are eligible in the same cycle, the one that was not granted last wins. After reset, the first such tie goes to the write engine. A write is eligible when the input FIFO is non-empty and memory is not full. A read is eligible when the output FIFO is not full and memory is not empty.
- R9: A synchronous reset empties both staging FIFOs, clears the occupancy and returns both positions to the ring base. Afterwards `in_ready` is 1, `out_valid` is 0, no command is issued, and the next write goes to RING_BASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Sink byte |
| in_valid | input | 1 | Sink byte is present |
| in_ready | output | 1 | Sink can accept a byte |
| out_data | output | DATA_W | Source byte |
| out_valid | output | 1 | Source byte is present |
| out_ready | input | 1 | Downstream takes the byte |
| mem_address | output | MEM_AW | Word address of the command |
| mem_write | output | 1 | Write command |
| mem_read | output | 1 | Read command |
| mem_writedata | output | DATA_W | Write word |
| mem_waitrequest | input | 1 | Memory stalls the command |
| mem_readdata | input | DATA_W | Returned read word |
| mem_readdatavalid | input | 1 | Returned read word is present |

## Verification
The hardest case to reach is a real tie at the memory port: both engines eligible in the same cycle, with memory at or near full, so that arbitration and the full/empty guards act together. The bench reaches it with a directed sequence. It first stalls the output so that memory and both staging FIFOs fill to the brim. It then opens the output while keeping the input saturated, and it checks that accepted commands strictly alternate between read and write. A long random phase follows, with random wait states and random read latency, then a reset in the middle of traffic. Together these drive the ring positions through several wraps and catch stale data left by a cancelled read.

// File: rtl/ext_fifo_pkg.sv
package ext_fifo_pkg;

  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_WRITE = 2'd1,
    MS_READ  = 2'd2,
    MS_WAIT  = 2'd3
  } mstate_e;

  // Next position on a ring of ring_words entries.
  function automatic int unsigned ring_next(int unsigned pos, int unsigned ring_words);
    return (pos + 1) % ring_words;
  endfunction

  // Memory word address of a ring position.
  function automatic int unsigned ring_addr(int unsigned base, int unsigned pos);
    return base + pos;
  endfunction

endpackage

// File: rtl/stage_fifo.sv
module stage_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_pos, rd_pos;
  logic [AW:0]   fill;
  logic          do_push, do_pop;

  assign full    = (fill == (AW+1)'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rd_pos];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_pos] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pos <= '0;
      rd_pos <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_pos <= AW'(ext_fifo_pkg::ring_next(int'(wr_pos), DEPTH));
      if (do_pop)  rd_pos <= AW'(ext_fifo_pkg::ring_next(int'(rd_pos), DEPTH));
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic req_wr,
  input  logic req_rd,
  output logic gnt_wr,
  output logic gnt_rd
);
  logic last_wr;

  assign gnt_wr = req_wr && (!req_rd || !last_wr);
  assign gnt_rd = req_rd && (!req_wr || last_wr);

  always_ff @(posedge clk) begin
    if (rst)                   last_wr <= 1'b0;
    else if (gnt_wr || gnt_rd) last_wr <= gnt_wr;
  end
endmodule

// File: rtl/ext_fifo_ctrl.sv
module ext_fifo_ctrl #(
  parameter int DATA_W      = 8,
  parameter int MEM_AW      = 8,
  parameter int RING_LOG2   = 4,
  parameter int RING_BASE   = 32,
  parameter int STAGE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MEM_AW-1:0] mem_address,
  output logic              mem_write,
  output logic              mem_read,
  output logic [DATA_W-1:0] mem_writedata,
  input  logic              mem_waitrequest,
  input  logic [DATA_W-1:0] mem_readdata,
  input  logic              mem_readdatavalid
);
  import ext_fifo_pkg::*;

  localparam int RING_WORDS = 1 << RING_LOG2;
  localparam int OCC_W      = RING_LOG2 + 1;

  mstate_e              state;
  logic [RING_LOG2-1:0] wptr, rptr;
  logic [OCC_W-1:0]     occ;

  logic [DATA_W-1:0] ibuf_head;
  logic              ibuf_full, ibuf_empty;
  logic              obuf_full, obuf_empty;

  // Named internal events, also observed by the checker.
  logic is_idle, wr_elig, rd_elig, arb_both;
  logic gnt_wr, gnt_rd, take_wr, take_rd;
  logic wr_done, rd_accept, rd_done, rd_waiting;

  assign is_idle    = (state == MS_IDLE);
  assign wr_elig    = !ibuf_empty && (occ != OCC_W'(RING_WORDS));
  assign rd_elig    = !obuf_full && (occ != '0);
  assign arb_both   = is_idle && wr_elig && rd_elig;
  assign take_wr    = is_idle && gnt_wr;
  assign take_rd    = is_idle && gnt_rd;
  assign wr_done    = (state == MS_WRITE) && !mem_waitrequest;
  assign rd_accept  = (state == MS_READ) && !mem_waitrequest;
  assign rd_waiting = (state == MS_WAIT);
  assign rd_done    = rd_waiting && mem_readdatavalid;

  stage_fifo #(.W(DATA_W), .DEPTH(STAGE_DEPTH)) in_stage_i (
    .clk(clk), .rst(rst),
    .push(in_valid), .din(in_data),
    .pop(wr_done), .head(ibuf_head),
    .full(ibuf_full), .empty(ibuf_empty)
  );

  stage_fifo #(.W(DATA_W), .DEPTH(STAGE_DEPTH)) out_stage_i (
    .clk(clk), .rst(rst),
    .push(rd_done), .din(mem_readdata),
    .pop(out_ready), .head(out_data),
    .full(obuf_full), .empty(obuf_empty)
  );

  rr_arbiter arb_i (
    .clk(clk), .rst(rst),
    .req_wr(is_idle && wr_elig), .req_rd(is_idle && rd_elig),
    .gnt_wr(gnt_wr), .gnt_rd(gnt_rd)
  );

  assign in_ready      = !ibuf_full;
  assign out_valid     = !obuf_empty;
  assign mem_write     = (state == MS_WRITE);
  assign mem_read      = (state == MS_READ);
  assign mem_writedata = ibuf_head;

  always_comb begin
    mem_address = '0;
    if (mem_write) mem_address = MEM_AW'(ring_addr(RING_BASE, int'(wptr)));
    if (mem_read)  mem_address = MEM_AW'(ring_addr(RING_BASE, int'(rptr)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= MS_IDLE;
      wptr  <= '0;
      rptr  <= '0;
      occ   <= '0;
    end else begin
      case (state)
        MS_IDLE:  if (take_wr) state <= MS_WRITE;
                  else if (take_rd) state <= MS_READ;
        MS_WRITE: if (wr_done) state <= MS_IDLE;
        MS_READ:  if (rd_accept) state <= MS_WAIT;
        MS_WAIT:  if (rd_done) state <= MS_IDLE;
        default:  state <= MS_IDLE;
      endcase
      if (wr_done) begin
        wptr <= RING_LOG2'(ring_next(int'(wptr), RING_WORDS));
        occ  <= occ + 1'b1;
      end
      if (rd_done) begin
        rptr <= RING_LOG2'(ring_next(int'(rptr), RING_WORDS));
        occ  <= occ - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ext_fifo_ctrl_chk.sv
module ext_fifo_ctrl_chk #(
  parameter int DATA_W    = 8,
  parameter int MEM_AW    = 8,
  parameter int RING_LOG2 = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 mem_write,
  input logic                 mem_read,
  input logic                 mem_waitrequest,
  input logic [MEM_AW-1:0]    mem_address,
  input logic [DATA_W-1:0]    mem_writedata,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [DATA_W-1:0]    out_data,
  input logic [RING_LOG2:0]   occ,
  input logic [RING_LOG2-1:0] wptr,
  input logic [RING_LOG2-1:0] rptr,
  input logic                 rd_waiting,
  input logic                 arb_both,
  input logic                 take_wr,
  input logic                 take_rd
);
  localparam int RING_WORDS = 1 << RING_LOG2;

  logic seen_wr_last;
  always_ff @(posedge clk) begin
    if (rst)                    seen_wr_last <= 1'b0;
    else if (take_wr || take_rd) seen_wr_last <= take_wr;
  end

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= (RING_LOG2+1)'(RING_WORDS));

  assert_no_write_full_R3: assert property (@(posedge clk) disable iff (rst)
    mem_write |-> occ < (RING_LOG2+1)'(RING_WORDS));

  assert_no_read_empty_R4: assert property (@(posedge clk) disable iff (rst)
    mem_read |-> occ != '0);

  assert_ptr_gap_R5: assert property (@(posedge clk) disable iff (rst)
    occ[RING_LOG2-1:0] == RING_LOG2'(wptr - rptr));

  assert_hold_write_R6: assert property (@(posedge clk) disable iff (rst)
    mem_write && mem_waitrequest |=> mem_write && $stable(mem_address) && $stable(mem_writedata));

  assert_hold_read_R6: assert property (@(posedge clk) disable iff (rst)
    mem_read && mem_waitrequest |=> mem_read && $stable(mem_address));

  assert_cmd_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(mem_write && mem_read));

  assert_one_read_R7: assert property (@(posedge clk) disable iff (rst)
    rd_waiting |-> !mem_read && !mem_write);

  assert_rr_write_turn_R8: assert property (@(posedge clk) disable iff (rst)
    arb_both && take_wr |-> !seen_wr_last);

  assert_rr_read_turn_R8: assert property (@(posedge clk) disable iff (rst)
    arb_both && take_rd |-> seen_wr_last);

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind ext_fifo_ctrl ext_fifo_ctrl_chk #(
  .DATA_W(DATA_W), .MEM_AW(MEM_AW), .RING_LOG2(RING_LOG2)
) chk_i (
  .clk(clk), .rst(rst),
  .mem_write(mem_write), .mem_read(mem_read), .mem_waitrequest(mem_waitrequest),
  .mem_address(mem_address), .mem_writedata(mem_writedata),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .occ(occ), .wptr(wptr), .rptr(rptr), .rd_waiting(rd_waiting),
  .arb_both(arb_both), .take_wr(take_wr), .take_rd(take_rd)
);

// File: tb/ext_fifo_ctrl_tb.sv
module ext_fifo_ctrl_tb_top;
  localparam int DATA_W      = 8;
  localparam int MEM_AW      = 8;
  localparam int RING_LOG2   = 4;
  localparam int RING_BASE   = 32;
  localparam int STAGE_DEPTH = 4;
  localparam int RING_WORDS  = 1 << RING_LOG2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] in_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic [DATA_W-1:0] out_data;
  logic out_valid, out_ready = 1'b0;
  logic [MEM_AW-1:0] mem_address;
  logic mem_write, mem_read;
  logic [DATA_W-1:0] mem_writedata;
  logic mem_waitrequest = 1'b0;
  logic [DATA_W-1:0] mem_readdata = '0;
  logic mem_readdatavalid = 1'b0;

  always #4 clk = ~clk;

  ext_fifo_ctrl #(
    .DATA_W(DATA_W), .MEM_AW(MEM_AW), .RING_LOG2(RING_LOG2),
    .RING_BASE(RING_BASE), .STAGE_DEPTH(STAGE_DEPTH)
  ) dut_i (
    .clk(clk), .rst(rst),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .mem_address(mem_address), .mem_write(mem_write), .mem_read(mem_read),
    .mem_writedata(mem_writedata), .mem_waitrequest(mem_waitrequest),
    .mem_readdata(mem_readdata), .mem_readdatavalid(mem_readdatavalid)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] mem_m [1 << MEM_AW];
  logic [DATA_W-1:0] sb [$];
  int wcount, rcount, occ_m, n_in;
  bit pend; int pend_cnt; logic [MEM_AW-1:0] pend_addr;
  bit prev_wr, prev_rd, prev_wait;
  logic [MEM_AW-1:0] prev_addr; logic [DATA_W-1:0] prev_wdata;
  int p_in, p_out, p_wait, max_lat;
  bit alt_on; byte last_cmd;

  function automatic int exp_addr(int n);
    return RING_BASE + (n % RING_WORDS);
  endfunction

  function automatic bit roll(int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic clear_models();
    sb.delete();
    wcount = 0; rcount = 0; occ_m = 0; n_in = 0;
    pend = 0; pend_cnt = 0; pend_addr = '0;
    prev_wr = 0; prev_rd = 0; prev_wait = 0;
    prev_addr = '0; prev_wdata = '0;
    last_cmd = "-";
  endtask

  // One cycle: drive at the falling edge, then model the coming rising edge.
  task automatic step();
    @(negedge clk);
    mem_readdatavalid = 1'b0;
    if (rst) begin
      in_valid = 1'b0;
      clear_models();
      return;
    end
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_readdatavalid = 1'b1;
        mem_readdata = mem_m[pend_addr];
        pend = 0;
        occ_m--;
      end else pend_cnt--;
    end
    in_valid = roll(p_in);
    in_data = DATA_W'($urandom);
    out_ready = roll(p_out);
    mem_waitrequest = roll(p_wait);
    #1;
    // R6: stalled request held
    if (prev_wait && (prev_wr || prev_rd)) begin
      check(mem_write == prev_wr && mem_read == prev_rd, "R6 cmd", {mem_write, mem_read}, {prev_wr, prev_rd});
      check(mem_address == prev_addr, "R6 addr", mem_address, prev_addr);
      if (prev_wr) check(mem_writedata == prev_wdata, "R6 wdata", mem_writedata, prev_wdata);
    end
    check(!(mem_write && mem_read), "R7 exclusive", {mem_write, mem_read}, 0);
    if (pend || mem_readdatavalid) check(!mem_read && !mem_write, "R7 outstanding", {mem_write, mem_read}, 0);
    if (mem_write) check(occ_m < RING_WORDS, "R3 write while full", occ_m, RING_WORDS - 1);
    if (mem_read) check(occ_m > 0, "R4 read while empty", occ_m, 1);
    // streaming handshakes
    if (in_valid && in_ready) begin sb.push_back(in_data); n_in++; end
    if (out_valid && out_ready) begin
      if (sb.size() == 0) check(0, "R2 extra byte", out_data, -1);
      else begin
        logic [DATA_W-1:0] e;
        e = sb.pop_front();
        check(out_data == e, "R2 order", out_data, e);
      end
    end
    // memory acceptance at the coming edge
    if (mem_write && !mem_waitrequest) begin
      check(int'(mem_address) == exp_addr(wcount), "R5 write addr", mem_address, exp_addr(wcount));
      mem_m[mem_address] = mem_writedata;
      wcount++; occ_m++;
      if (alt_on) check(last_cmd != "W", "R8 alternate", last_cmd, "R");
      last_cmd = "W";
    end
    if (mem_read && !mem_waitrequest) begin
      check(int'(mem_address) == exp_addr(rcount), "R5 read addr", mem_address, exp_addr(rcount));
      rcount++;
      pend = 1; pend_addr = mem_address;
      pend_cnt = (max_lat > 0) ? int'($urandom % (max_lat + 1)) : 0;
      if (alt_on) check(last_cmd != "R", "R8 alternate", last_cmd, "W");
      last_cmd = "R";
    end
    prev_wr = mem_write; prev_rd = mem_read; prev_wait = mem_waitrequest;
    prev_addr = mem_address; prev_wdata = mem_writedata;
  endtask

  task automatic drain(string tag);
    p_in = 0; p_out = 100;
    for (int i = 0; i < 3000 && (sb.size() != 0 || pend); i++) step();
    for (int i = 0; i < 20; i++) step();
    check(sb.size() == 0, tag, sb.size(), 0);
    check(out_valid == 1'b0, tag, out_valid, 0);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h1F2E3D4C);
    clear_models();
    alt_on = 0;
    p_in = 0; p_out = 0; p_wait = 0; max_lat = 0;
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    #1;
    // R9: reset state
    check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    check(!mem_write && !mem_read, "R9 no command", {mem_write, mem_read}, 0);

    // R1/R3: stalled output, saturated input
    p_in = 100; p_out = 0;
    for (int i = 0; i < 200; i++) step();
    check(n_in == RING_WORDS + 2*STAGE_DEPTH, "R1 accepted count", n_in, RING_WORDS + 2*STAGE_DEPTH);
    check(in_ready == 1'b0, "R1 in_ready low when full", in_ready, 0);
    check(occ_m == RING_WORDS, "R3 memory full", occ_m, RING_WORDS);
    check(wcount == RING_WORDS + STAGE_DEPTH, "R5 writes wrapped", wcount, RING_WORDS + STAGE_DEPTH);

    // R8: both engines busy, commands must alternate
    p_out = 100;
    for (int i = 0; i < 12; i++) step();
    alt_on = 1;
    for (int i = 0; i < 100; i++) step();
    alt_on = 0;
    drain("R2 drain after tie phase");

    // random traffic
    p_in = 60; p_out = 50; p_wait = 30; max_lat = 2;
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) begin p_in = 20 + int'($urandom % 80); p_out = 10 + int'($urandom % 90); end
      step();
    end
    drain("R2 drain after random");
    check(wcount == rcount && wcount > 100, "R5 totals", rcount, wcount);

    // R9: reset in the middle of traffic
    p_in = 100; p_out = 0; p_wait = 20; max_lat = 1;
    for (int i = 0; i < 30; i++) step();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    p_in = 0; p_out = 0; p_wait = 0;
    step();
    check(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    check(!mem_write && !mem_read, "R9 idle after reset", {mem_write, mem_read}, 0);
    p_in = 100;
    for (int i = 0; i < 6; i++) step();
    p_in = 0;
    for (int i = 0; i < 10; i++) step();
    check(wcount > 0, "R9 write at base seen", wcount, 1);
    drain("R9 only post-reset bytes");

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule